// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit data ports, called A and B, and moves data between them in either direction. For each direction the driven port carries one of two values, chosen by a per-direction select. One is the live value on the opposite port. The other is the word most recently captured into that direction's storage register. Each storage register has a clock of its own. On every rising edge of that clock the register captures its source port, whatever the output enable and direction inputs are set to.

An active-low output enable and a direction input set the transfer mode. There are three modes. MODE_ISOLATE: the enable is high, neither port drives, and both are inputs. MODE_A_TO_B: the enable is low and direction is high, so port B drives. MODE_B_TO_A: the enable is low and direction is low, so port A drives. The mode is decoded combinationally from the two inputs and has no state of its own. It moves between any two modes as soon as the enable or direction input changes. The decode has six transitions: ISOLATE to A_TO_B, ISOLATE to B_TO_A, A_TO_B to B_TO_A, B_TO_A to A_TO_B, A_TO_B to ISOLATE, and B_TO_A to ISOLATE.

Each bidirectional port is split into an input, an output value and a drive enable, and an outer wrapper may resolve these onto a tri-state net. Each output value always carries the selected live or stored word, including when its drive enable is low. A synchronous reset clears each register on that register's own clock edge. Before the first reset the register contents are undefined.

Top module: `regbus_xcvr`

## Requirements
- R1: When `oe_n` is 1 (MODE_ISOLATE), `a_oe` and `b_oe` are both 0.
- R2: When `oe_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R3: When `sel_ab` is 0, `b_out` equals `a_in` combinationally, with no clock needed.
- R4: When `sel_ab` is 1, `b_out` equals the contents of the A-side register.
- R5: When `sel_ba` is 0, `a_out` equals `b_in` combinationally.
- R6: When `sel_ba` is 1, `a_out` equals the contents of the B-side register.
- R7: Every rising edge of `clk_ab` with `rst` = 0 loads `a_in` into the A-side register, for any value of `oe_n` and `dir`, including MODE_ISOLATE.
- R8: Every rising edge of `clk_ba` with `rst` = 0 loads `b_in` into the B-side register, for any value of `oe_n` and `dir`, including MODE_ISOLATE.
- R9: In stored mode, the word captured on an edge of the active direction's clock appears on the driven port right after that same edge.
- R10: `rst` = 1 at a rising edge of `clk_ab` clears the A-side register to 0. `rst` = 1 at a rising edge of `clk_ba` clears the B-side register to 0. Each register is cleared only by its own clock.
- R11: An edge of one clock leaves the other direction's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst | input | 1 | Synchronous active-high reset, sampled on each register's own clock |
| oe_n | input | 1 | Active-low output enable; 1 gives MODE_ISOLATE |
| dir | input | 1 | 1: B port drives; 0: A port drives |
| sel_ab | input | 1 | B output source: 0 live A bus, 1 A-side register |
| sel_ba | input | 1 | A output source: 0 live B bus, 1 B-side register |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Value port A drives when enabled |
| a_oe | output | 1 | Drive enable of port A |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Value port B drives when enabled |
| b_oe | output | 1 | Drive enable of port B |

## Verification
The bench sweeps all sixteen combinations of enable, direction and the two selects. In each one it captures on both clocks and then changes the inputs without clocking, which separates stored words from live ones. A design that dropped captures in MODE_ISOLATE would show a stale stored word, because the outputs carry the selected value even when not driven. A design with swapped clocks or shared registers would let a B-side edge corrupt the A-side word. The bench also clears each register separately under reset and checks the other one. A design that reset both on either clock would lose the surviving word.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_A_TO_B  = 2'd1,
        MODE_B_TO_A  = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/regbus_mode_dec.sv
module regbus_mode_dec
    import regbus_pkg::*;
(
    input  logic       oe_n,
    input  logic       dir,
    output xfer_mode_e mode,
    output logic       a_oe,
    output logic       b_oe
);

    always_comb begin
        unique case ({oe_n, dir})
            2'b00:   mode = MODE_B_TO_A;
            2'b01:   mode = MODE_A_TO_B;
            default: mode = MODE_ISOLATE;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_A_TO_B: begin
                a_oe = 1'b0;
                b_oe = 1'b1;
            end
            MODE_B_TO_A: begin
                a_oe = 1'b1;
                b_oe = 1'b0;
            end
            default: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/regbus_capture_reg.sv
module regbus_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/regbus_out_mux.sv
module regbus_out_mux #(
    parameter int WIDTH = 8
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (use_stored)
            1'b1:    y = stored;
            default: y = live;
        endcase
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    localparam int NDIR = 2;
    localparam int DAB  = 0;
    localparam int DBA  = 1;

    xfer_mode_e       mode;
    logic [WIDTH-1:0] src   [NDIR];
    logic [WIDTH-1:0] held  [NDIR];
    logic [WIDTH-1:0] dst   [NDIR];
    logic             clks  [NDIR];
    logic             sels  [NDIR];

    assign src[DAB]  = a_in;
    assign src[DBA]  = b_in;
    assign clks[DAB] = clk_ab;
    assign clks[DBA] = clk_ba;
    assign sels[DAB] = sel_ab;
    assign sels[DBA] = sel_ba;

    regbus_mode_dec u_mode (
        .oe_n (oe_n),
        .dir  (dir),
        .mode (mode),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );

    for (genvar g = 0; g < NDIR; g++) begin : g_path
        regbus_capture_reg #(.WIDTH(WIDTH)) u_reg (
            .clk (clks[g]),
            .rst (rst),
            .d   (src[g]),
            .q   (held[g])
        );

        regbus_out_mux #(.WIDTH(WIDTH)) u_mux (
            .use_stored (sels[g]),
            .live       (src[g]),
            .stored     (held[g]),
            .y          (dst[g])
        );
    end

    assign b_out = dst[DAB];
    assign a_out = dst[DBA];

    logic unused_mode;
    assign unused_mode = ^mode;

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe
);

    logic ab_loaded;
    logic ba_loaded;

    always_ff @(posedge clk_ab) ab_loaded <= !rst;
    always_ff @(posedge clk_ba) ba_loaded <= !rst;

    a_r1_isolate: assert property (@(posedge clk_ab) disable iff (rst)
        oe_n |-> (!a_oe && !b_oe));

    a_r2_drive_b: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_n && dir) |-> (b_oe && !a_oe));

    a_r2_drive_a: assert property (@(posedge clk_ba) disable iff (rst)
        (!oe_n && !dir) |-> (a_oe && !b_oe));

    a_r3_live_ab: assert property (@(posedge clk_ab) disable iff (rst)
        !sel_ab |-> (b_out == a_in));

    a_r5_live_ba: assert property (@(posedge clk_ba) disable iff (rst)
        !sel_ba |-> (a_out == b_in));

    a_r4_stored_ab: assert property (@(posedge clk_ab) disable iff (rst)
        (ab_loaded && sel_ab) |-> (b_out == $past(a_in)));

    a_r6_stored_ba: assert property (@(posedge clk_ba) disable iff (rst)
        (ba_loaded && sel_ba) |-> (a_out == $past(b_in)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  HALF       = CLK_PERIOD / 2;
    localparam int  W          = 8;

    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         rst = 1'b1;
    logic         oe_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    logic [W-1:0] ra = '0;
    logic [W-1:0] rb = '0;

    regbus_xcvr #(.WIDTH(W)) u_regbus_xcvr (
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .rst    (rst),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_in   (b_in),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_ab();
        #HALF clk_ab = 1'b1;
        #HALF clk_ab = 1'b0;
    endtask

    task automatic pulse_ba();
        #HALF clk_ba = 1'b1;
        #HALF clk_ba = 1'b0;
    endtask

    task automatic check_all(input string ctx);
        logic en_a;
        logic en_b;
        en_a = !oe_n && !dir;
        en_b = !oe_n && dir;
        #1;
        chk({ctx, oe_n ? " R1 a_oe" : " R2 a_oe"}, W'(a_oe), W'(en_a));
        chk({ctx, oe_n ? " R1 b_oe" : " R2 b_oe"}, W'(b_oe), W'(en_b));
        chk({ctx, sel_ab ? " R4 b_out" : " R3 b_out"}, b_out, sel_ab ? ra : a_in);
        chk({ctx, sel_ba ? " R6 a_out" : " R5 a_out"}, a_out, sel_ba ? rb : b_in);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        sel_ab = 1'b1;
        sel_ba = 1'b1;
        a_in = 8'h5A;
        b_in = 8'hC3;
        pulse_ab();
        pulse_ba();
        rst = 1'b0;
        ra = '0;
        rb = '0;
        check_all("R10 reset state");

        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] pa;
            logic [W-1:0] pb;
            pa = W'(i * 37 + 5);
            pb = W'(i * 91 + 200) ^ 8'hA5;
            {oe_n, dir, sel_ab, sel_ba} = 4'(i);
            a_in = pa;
            b_in = pb;
            check_all("sweep");

            pulse_ab();
            ra = pa;
            check_all("R7 R9 capture A");

            a_in = ~pa;
            check_all("R3 R4 A input moved");

            pulse_ba();
            rb = pb;
            check_all("R8 R9 R11 capture B");

            b_in = pb + 8'd1;
            check_all("R5 R6 B input moved");

            pulse_ab();
            ra = ~pa;
            check_all("R7 R11 recapture A");
        end

        oe_n = 1'b1;
        sel_ab = 1'b1;
        sel_ba = 1'b1;
        rst = 1'b1;
        pulse_ab();
        ra = '0;
        check_all("R10 R11 reset A only");
        chk("R10 B kept", a_out, rb);

        pulse_ba();
        rb = '0;
        check_all("R10 reset B");
        rst = 1'b0;

        oe_n = 1'b0;
        dir = 1'b1;
        a_in = 8'hFF;
        pulse_ab();
        ra = 8'hFF;
        check_all("R9 all ones");
        chk("R9 stored b_out", b_out, 8'hFF);

        dir = 1'b0;
        b_in = 8'h00;
        pulse_ba();
        rb = 8'h00;
        check_all("R9 B to A");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule